// File: doc/BRIEF.md
# Serial Flash Operation Sequencer

This block runs complete serial-flash operations on an SPI bus without software help per byte. A host hands it one descriptor (an opcode, up to three address bytes, an operation class, a data length and, for status waits, a mask and an expected value). The block then drives chip select, clock and data in SPI mode 0 (clock idles low, data sampled on the rising edge, most significant bit first). Payload bytes for writes come in on a ready/valid stream. Bytes read from the flash leave on a second ready/valid stream.

Four classes share one engine. A plain command sends only the opcode and address. A write class follows the command with payload bytes. A read class follows it with 0xFF filler bytes and returns what the flash shifts back. A status-wait class keeps chip select low and re-reads the status byte until the masked value equals the expected one. It then clocks one more filler byte and releases the select. During command and write phases the bytes received are discarded. The block signals completion only after chip select has gone high again and the minimum deselect gap has passed.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, cs_n_o is high, sclk_o is low, busy_o, done_o and rd_valid_o are low, and desc_ready_o is high.
- R2: Each byte is sent with the clock idling low and most significant bit first. Mosi is stable while the clock is high. Every byte of one operation falls inside a single low period of cs_n_o.
- R3: The command part is opcode_i followed by addr_cnt_i address bytes. These bytes are taken from the low end of addr_i, most significant first. addr_cnt_i ranges from 0 to 3.
- R4: op_cls_i encodes the class: 0 command only, 1 write, 2 read, 3 status wait. A command-only operation sends exactly the command bytes.
- R5: The write class sends data_len_i bytes from the write stream after the command, in arrival order. No byte appears on the read stream.
- R6: The read class sends data_len_i bytes of 0xFF after the command. It presents each received byte on the read stream in order. A byte that is not taken stays valid and unchanged.
- R7: The status-wait class reads status bytes (sending 0xFF) until (status AND poll_mask_i) equals poll_match_i. It then sends one extra 0xFF and releases chip select. Nothing appears on the read stream.
- R8: A write or read class with data_len_i of zero behaves as command only.
- R9: done_o is a one-cycle pulse that occurs exactly CLK_DIV cycles after cs_n_o returns high. busy_o is high from the cycle after acceptance until done_o, and falls in the same cycle that done_o rises.
- R10: A descriptor is accepted only while idle. desc_valid_i while busy has no effect on the bytes sent. Chip select stays high whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Sequencer idle, descriptor will be taken |
| op_cls_i | input | 2 | Operation class |
| addr_cnt_i | input | 2 | Number of address bytes (0..3) |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 24 | Address |
| data_len_i | input | LEN_W | Payload byte count for write/read |
| poll_mask_i | input | 8 | Status bits to compare |
| poll_match_i | input | 8 | Expected masked status |
| wr_valid_i | input | 1 | Write payload byte valid |
| wr_data_i | input | 8 | Write payload byte |
| wr_ready_o | output | 1 | Write payload byte taken |
| rd_valid_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| rd_ready_i | input | 1 | Read byte taken |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation complete pulse |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to flash |
| cs_n_o | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data from flash |

## Verification
busy_o rises one clock after the accepting edge. Each clock half lasts CLK_DIV cycles. A read byte becomes valid one cycle after the last clock high phase of its byte ends. done_o follows the rise of cs_n_o by exactly CLK_DIV cycles. The bench samples every output on the falling clock edge and counts falling edges from the observed rise of chip select to the observed done pulse. It also makes its stream handshake decisions at the falling edge, from registered ready/valid values, so each one takes effect at the next rising edge. A flash model on the serial pins logs every byte per select window. The bench compares that log and the read stream with streams it builds itself from the descriptor.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_POLL = 2'd3
  } op_cls_e;

  typedef enum logic [2:0] {M_IDLE, M_LOW, M_HIGH, M_HOLD, M_GAP} mst_st_e;

  typedef enum logic [2:0] {Q_IDLE, Q_CMD, Q_WR, Q_RD, Q_POLL, Q_TAIL, Q_END} seq_st_e;

  typedef struct packed {
    logic [7:0] data;
    logic       eot;   // release select after this byte
    logic       ign;   // discard received byte
  } chr_t;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_seq_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chr_valid_i,
  input  chr_t       chr_i,
  output logic       chr_ready_o,
  output logic       chr_done_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       xfer_end_o,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       cs_n_o,
  input  logic       miso_i
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  mst_st_e          st_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q, rx_q;
  logic             eot_q, ign_q, done_q;
  logic             div_end;

  assign div_end = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      eot_q  <= 1'b0;
      ign_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        M_IDLE, M_HOLD: begin
          if (chr_valid_i) begin
            st_q  <= M_LOW;
            div_q <= '0;
            bit_q <= 3'd7;
            tx_q  <= chr_i.data;
            eot_q <= chr_i.eot;
            ign_q <= chr_i.ign;
          end
        end
        M_LOW: begin
          if (div_end) begin
            st_q  <= M_HIGH;
            div_q <= '0;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        M_HIGH: begin
          if (div_end) begin
            div_q <= '0;
            if (bit_q == 3'd0) begin
              done_q <= 1'b1;
              st_q   <= eot_q ? M_GAP : M_HOLD;
            end else begin
              bit_q <= bit_q - 1'b1;
              tx_q  <= {tx_q[6:0], 1'b0};
              st_q  <= M_LOW;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        M_GAP: begin
          if (div_end) begin
            st_q  <= M_IDLE;
            div_q <= '0;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign chr_ready_o = (st_q == M_IDLE) || (st_q == M_HOLD);
  assign chr_done_o  = done_q;
  assign rx_valid_o  = done_q && !ign_q;
  assign rx_byte_o   = rx_q;
  assign xfer_end_o  = (st_q == M_GAP) && div_end;
  assign sclk_o      = (st_q == M_HIGH);
  assign mosi_o      = tx_q[7];
  assign cs_n_o      = (st_q == M_IDLE) || (st_q == M_GAP);
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned ADDR_BYTES = 3,
  localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1),
  localparam int unsigned ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [1:0]        op_cls_i,
  input  logic [CNT_W-1:0]  addr_cnt_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  data_len_i,
  input  logic [7:0]        poll_mask_i,
  input  logic [7:0]        poll_match_i,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_data_i,
  output logic              wr_ready_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  input  logic              rd_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              chr_valid_o,
  output chr_t              chr_o,
  input  logic              chr_ready_i,
  input  logic              chr_done_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              xfer_end_i
);
  seq_st_e           st_q;
  op_cls_e           cls_q;
  logic [CNT_W-1:0]  n_addr_q, idx_q;
  logic [7:0]        opc_q, mask_q, match_q, rd_data_q;
  logic [ADDR_W-1:0] addr_q, addr_sh;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              fl_q, fl_poll_q, rd_valid_q, done_q;
  logic [7:0]        cmd_byte;
  logic              cmd_last, no_data, data_last, hs, poll_hit;

  assign addr_sh   = addr_q >> {n_addr_q - idx_q, 3'b000};
  assign cmd_byte  = (idx_q == '0) ? opc_q : addr_sh[7:0];
  assign cmd_last  = (idx_q == n_addr_q);
  assign no_data   = (cls_q == OP_CMD) ||
                     (((cls_q == OP_WR) || (cls_q == OP_RD)) && (len_q == '0));
  assign data_last = (cnt_q == len_q - 1'b1);
  assign poll_hit  = chr_done_i && fl_poll_q && ((rx_byte_i & mask_q) == match_q);

  always_comb begin
    chr_valid_o = 1'b0;
    chr_o.data  = FILL_BYTE;
    chr_o.eot   = 1'b0;
    chr_o.ign   = 1'b1;
    wr_ready_o  = 1'b0;
    case (st_q)
      Q_CMD: begin
        chr_valid_o = !fl_q;
        chr_o.data  = cmd_byte;
        chr_o.eot   = cmd_last && no_data;
      end
      Q_WR: begin
        chr_valid_o = !fl_q && wr_valid_i;
        chr_o.data  = wr_data_i;
        chr_o.eot   = data_last;
        wr_ready_o  = !fl_q && chr_ready_i;
      end
      Q_RD: begin
        // hold the clock while the previous byte waits on the read stream
        chr_valid_o = !fl_q && !rd_valid_q;
        chr_o.eot   = data_last;
        chr_o.ign   = 1'b0;
      end
      Q_POLL: begin
        chr_valid_o = !fl_q;
        chr_o.ign   = 1'b0;
      end
      Q_TAIL: begin
        chr_valid_o = !fl_q;
        chr_o.eot   = 1'b1;
      end
      default: ;
    endcase
  end

  assign hs = chr_valid_o && chr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= Q_IDLE;
      cls_q      <= OP_CMD;
      n_addr_q   <= '0;
      idx_q      <= '0;
      opc_q      <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      cnt_q      <= '0;
      mask_q     <= '0;
      match_q    <= '0;
      fl_q       <= 1'b0;
      fl_poll_q  <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (chr_done_i) begin
        fl_q      <= 1'b0;
        fl_poll_q <= 1'b0;
      end
      if (hs) begin
        fl_q      <= 1'b1;
        fl_poll_q <= (st_q == Q_POLL);
      end
      if (rd_valid_q && rd_ready_i) rd_valid_q <= 1'b0;
      if (rx_valid_i && (cls_q == OP_RD)) begin
        rd_valid_q <= 1'b1;
        rd_data_q  <= rx_byte_i;
      end
      case (st_q)
        Q_IDLE: begin
          if (desc_valid_i) begin
            st_q     <= Q_CMD;
            cls_q    <= op_cls_e'(op_cls_i);
            n_addr_q <= (addr_cnt_i > CNT_W'(ADDR_BYTES)) ? CNT_W'(ADDR_BYTES) : addr_cnt_i;
            idx_q    <= '0;
            cnt_q    <= '0;
            opc_q    <= opcode_i;
            addr_q   <= addr_i;
            len_q    <= data_len_i;
            mask_q   <= poll_mask_i;
            match_q  <= poll_match_i;
          end
        end
        Q_CMD: begin
          if (hs) begin
            if (cmd_last) begin
              if (no_data)               st_q <= Q_END;
              else if (cls_q == OP_WR)   st_q <= Q_WR;
              else if (cls_q == OP_RD)   st_q <= Q_RD;
              else                       st_q <= Q_POLL;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        Q_WR, Q_RD: begin
          if (hs) begin
            if (data_last) st_q <= Q_END;
            else           cnt_q <= cnt_q + 1'b1;
          end
        end
        Q_POLL: if (poll_hit) st_q <= Q_TAIL;
        Q_TAIL: if (hs) st_q <= Q_END;
        Q_END: begin
          if (xfer_end_i) begin
            st_q   <= Q_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= Q_IDLE;
      endcase
    end
  end

  assign desc_ready_o = (st_q == Q_IDLE);
  assign busy_o       = (st_q != Q_IDLE);
  assign done_o       = done_q;
  assign rd_valid_o   = rd_valid_q;
  assign rd_data_o    = rd_data_q;
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_seq_pkg::*;
#(
  parameter int unsigned CLK_DIV    = 2,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned ADDR_BYTES = 3
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 desc_valid_i,
  output logic                                 desc_ready_o,
  input  logic [1:0]                           op_cls_i,
  input  logic [$clog2(ADDR_BYTES+1)-1:0]      addr_cnt_i,
  input  logic [7:0]                           opcode_i,
  input  logic [8*ADDR_BYTES-1:0]              addr_i,
  input  logic [LEN_W-1:0]                     data_len_i,
  input  logic [7:0]                           poll_mask_i,
  input  logic [7:0]                           poll_match_i,
  input  logic                                 wr_valid_i,
  input  logic [7:0]                           wr_data_i,
  output logic                                 wr_ready_o,
  output logic                                 rd_valid_o,
  output logic [7:0]                           rd_data_o,
  input  logic                                 rd_ready_i,
  output logic                                 busy_o,
  output logic                                 done_o,
  output logic                                 sclk_o,
  output logic                                 mosi_o,
  output logic                                 cs_n_o,
  input  logic                                 miso_i
);
  chr_t       chr;
  logic       chr_valid, chr_ready, chr_done, rx_valid, xfer_end;
  logic [7:0] rx_byte;

  spi_seq_ctrl #(
    .LEN_W     (LEN_W),
    .ADDR_BYTES(ADDR_BYTES)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .desc_valid_i(desc_valid_i),
    .desc_ready_o(desc_ready_o),
    .op_cls_i    (op_cls_i),
    .addr_cnt_i  (addr_cnt_i),
    .opcode_i    (opcode_i),
    .addr_i      (addr_i),
    .data_len_i  (data_len_i),
    .poll_mask_i (poll_mask_i),
    .poll_match_i(poll_match_i),
    .wr_valid_i  (wr_valid_i),
    .wr_data_i   (wr_data_i),
    .wr_ready_o  (wr_ready_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .rd_ready_i  (rd_ready_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .chr_valid_o (chr_valid),
    .chr_o       (chr),
    .chr_ready_i (chr_ready),
    .chr_done_i  (chr_done),
    .rx_valid_i  (rx_valid),
    .rx_byte_i   (rx_byte),
    .xfer_end_i  (xfer_end)
  );

  spi_byte_master #(
    .CLK_DIV(CLK_DIV)
  ) u_master (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chr_valid_i(chr_valid),
    .chr_i      (chr),
    .chr_ready_o(chr_ready),
    .chr_done_o (chr_done),
    .rx_valid_o (rx_valid),
    .rx_byte_o  (rx_byte),
    .xfer_end_o (xfer_end),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .cs_n_o     (cs_n_o),
    .miso_i     (miso_i)
  );
endmodule

// File: rtl/spi_flash_seq_chk.sv
module spi_flash_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       desc_valid_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       rd_ready_i,
  input logic       sclk_o,
  input logic       mosi_o,
  input logic       cs_n_o
);
  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_n_o); // R10
  AST_SCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o); // R2
  AST_MOSI_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o)); // R9
  AST_START_NEEDS_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(desc_valid_i)); // R10
  AST_RD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o))); // R6
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |=> cs_n_o); // R9
endmodule

bind spi_flash_seq spi_flash_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .desc_valid_i(desc_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .rd_ready_i  (rd_ready_i),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .cs_n_o      (cs_n_o)
);

// File: tb/spi_flash_seq_tb_top.sv
module spi_flash_seq_tb_top;
  localparam int CLK_DIV = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        desc_valid_i = 1'b0;
  logic        desc_ready_o;
  logic [1:0]  op_cls_i = '0;
  logic [1:0]  addr_cnt_i = '0;
  logic [7:0]  opcode_i = '0;
  logic [23:0] addr_i = '0;
  logic [7:0]  data_len_i = '0;
  logic [7:0]  poll_mask_i = '0;
  logic [7:0]  poll_match_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        wr_ready_o;
  logic        rd_valid_o;
  logic [7:0]  rd_data_o;
  logic        rd_ready_i = 1'b0;
  logic        busy_o, done_o, sclk_o, mosi_o, cs_n_o;
  logic        miso_i = 1'b1;

  always #4 clk_i = ~clk_i;

  spi_flash_seq #(.CLK_DIV(CLK_DIV)) dut_i (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // flash model
  logic [7:0] resp [64];
  logic [7:0] mlog [64];
  logic [7:0] msh = '0;
  int nbits = 0, nbytes = 0, cs_falls = 0;

  always @(negedge cs_n_o) begin
    nbits = 0;
    cs_falls++;
    miso_i = resp[0][7];
  end
  always @(posedge sclk_o) begin
    msh = {msh[6:0], mosi_o};
    nbits++;
    if (nbits % 8 == 0) begin
      mlog[(nbits / 8 - 1) % 64] = msh;
      nbytes = nbits / 8;
    end
  end
  always @(negedge sclk_o) if (!cs_n_o) miso_i = resp[(nbits / 8) % 64][7 - (nbits % 8)];

  // write stream source
  logic [7:0] wbuf [64];
  int widx = 0, wn = 0;
  bit w_hs = 0;
  always @(negedge clk_i) begin
    if (w_hs) widx++;
    wr_valid_i = (widx < wn) && (($urandom % 3) != 0);
    wr_data_i  = wbuf[widx % 64];
    w_hs       = wr_valid_i && wr_ready_o;
  end

  // read stream sink
  logic [7:0] rlog [64];
  int rcnt = 0;
  always @(negedge clk_i) begin
    rd_ready_i = (($urandom % 4) != 0);
    if (rd_valid_o && rd_ready_i) begin
      rlog[rcnt % 64] = rd_data_o;
      rcnt++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected finish before 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int cls, input int nadd, input logic [7:0] opc, input logic [23:0] addr,
                        input int len, input logic [7:0] mask, input logic [7:0] match, input bit spur);
    logic [7:0] exp [64];
    int nexp, hdr, nrd, lat, bad;
    bit prev_cs, got, nodata;
    @(negedge clk_i);
    nbytes = 0; cs_falls = 0; rcnt = 0; widx = 0; w_hs = 0;
    wn = (cls == 1) ? len : 0;
    desc_valid_i = 1'b1; op_cls_i = cls[1:0]; addr_cnt_i = nadd[1:0]; opcode_i = opc;
    addr_i = addr; data_len_i = len[7:0]; poll_mask_i = mask; poll_match_i = match;
    @(negedge clk_i);
    desc_valid_i = 1'b0;
    chk(busy_o && !desc_ready_o, "R9", "busy after accept", busy_o, 1);
    lat = -1; prev_cs = 1'b1; got = 0;
    for (int t = 0; t < 6000 && !got; t++) begin
      @(negedge clk_i);
      if (spur && t == 3) begin desc_valid_i = 1'b1; opcode_i = 8'hA5; op_cls_i = 2'd0; end
      if (spur && t == 4) desc_valid_i = 1'b0;
      if (cs_n_o && !prev_cs) lat = 0;
      else if (lat >= 0) lat++;
      prev_cs = cs_n_o;
      if (done_o) got = 1;
    end
    desc_valid_i = 1'b0;
    chk(got, "R9", "done seen", got, 1);
    chk(lat == CLK_DIV, "R9", "cs high to done", lat, CLK_DIV);
    chk(!busy_o, "R9", "busy low at done", busy_o, 0);
    // expected serial stream
    hdr = 1 + nadd;
    exp[0] = opc;
    for (int k = 1; k <= nadd; k++) exp[k] = 8'((addr >> (8 * (nadd - k))) & 24'hFF);
    nexp = hdr; nrd = 0;
    nodata = (cls == 0) || ((cls == 1 || cls == 2) && len == 0);
    if (!nodata) begin
      if (cls == 1) begin for (int k = 0; k < len; k++) exp[nexp++] = wbuf[k]; end
      else if (cls == 2) begin for (int k = 0; k < len; k++) exp[nexp++] = 8'hFF; nrd = len; end
      else begin
        int j = 0;
        while (((resp[hdr + j] & mask) != match) && j < 40) j++;
        for (int k = 0; k <= j + 1; k++) exp[nexp++] = 8'hFF;
      end
    end
    for (int t = 0; t < 40 && rd_valid_o; t++) @(negedge clk_i);
    chk(nbytes == nexp, (cls == 3) ? "R7" : (nodata ? "R8" : "R3"), "byte count", nbytes, nexp);
    bad = -1;
    for (int k = 0; k < nexp && k < nbytes; k++) if (bad < 0 && mlog[k] !== exp[k]) bad = k;
    chk(bad < 0, (cls == 1) ? "R5" : "R2", "mosi stream", (bad < 0) ? 0 : int'(mlog[bad]), (bad < 0) ? 0 : int'(exp[bad]));
    chk(cs_falls == 1, "R2", "select windows", cs_falls, 1);
    chk(rcnt == nrd, (cls == 2) ? "R6" : "R7", "read count", rcnt, nrd);
    bad = -1;
    for (int k = 0; k < nrd && k < rcnt; k++) if (bad < 0 && rlog[k] !== resp[hdr + k]) bad = k;
    chk(bad < 0, "R6", "read data", (bad < 0) ? 0 : int'(rlog[bad]), (bad < 0) ? 0 : int'(resp[hdr + bad]));
    if (spur) chk(!busy_o && desc_ready_o, "R10", "no op from busy descriptor", busy_o, 0);
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'h5EED_0042);
    for (int k = 0; k < 64; k++) begin resp[k] = 8'h00; wbuf[k] = 8'(k * 7 + 3); end
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(cs_n_o && !sclk_o, "R1", "cs/sclk idle", {cs_n_o, sclk_o}, 2);
    chk(!busy_o && !done_o && !rd_valid_o && desc_ready_o, "R1", "status idle",
        {busy_o, done_o, rd_valid_o, desc_ready_o}, 1);
    // read ID: opcode 0x9F, three bytes back (R6)
    resp[1] = 8'hEF; resp[2] = 8'h40; resp[3] = 8'h16;
    run_op(2, 0, 8'h9F, 24'h0, 3, 8'h00, 8'h00, 0);
    // command only (R4)
    run_op(0, 0, 8'h06, 24'h0, 5, 8'h00, 8'h00, 0);
    // command with 3-byte address (R3)
    run_op(0, 3, 8'h20, 24'h123456, 0, 8'h00, 8'h00, 0);
    // partial address widths (R3)
    run_op(0, 1, 8'h31, 24'hABCDEF, 0, 8'h00, 8'h00, 0);
    run_op(0, 2, 8'h32, 24'hABCDEF, 0, 8'h00, 8'h00, 0);
    // write payload (R5)
    run_op(1, 3, 8'h02, 24'h000100, 5, 8'h00, 8'h00, 0);
    // status wait: busy bit clears on fourth read (R7), busy descriptor ignored (R10)
    resp[1] = 8'h03; resp[2] = 8'h01; resp[3] = 8'h01; resp[4] = 8'h00;
    run_op(3, 0, 8'h05, 24'h0, 0, 8'h01, 8'h00, 1);
    // status wait matching on first read (R7)
    resp[1] = 8'h80;
    run_op(3, 0, 8'h05, 24'h0, 0, 8'h80, 8'h80, 0);
    // zero length data classes (R8)
    run_op(1, 3, 8'h02, 24'h0000AA, 0, 8'h00, 8'h00, 0);
    run_op(2, 3, 8'h03, 24'h0000AA, 0, 8'h00, 8'h00, 0);
    // random mix
    for (int n = 0; n < 40; n++) begin
      int cls, nadd, len, p, hdr;
      logic [7:0] mask, match, lsb;
      cls = $urandom % 4; nadd = $urandom % 4; len = $urandom % 9;
      hdr = 1 + nadd;
      mask = 8'($urandom) | 8'h01; match = 8'($urandom) & mask;
      lsb = mask & (~mask + 8'd1);
      for (int k = 0; k < 64; k++) begin resp[k] = 8'($urandom); wbuf[k] = 8'($urandom); end
      if (cls == 3) begin
        p = $urandom % 6;
        for (int j = 0; j < p; j++)
          if ((resp[hdr + j] & mask) == match) resp[hdr + j] = resp[hdr + j] ^ lsb;
        resp[hdr + p] = (resp[hdr + p] & ~mask) | match;
      end
      run_op(cls, nadd, 8'($urandom), 24'($urandom), len, mask, match, (n % 5) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule